// File: doc/BRIEF.md
# Multi-Mode Word DMA Channel

This block is a single direct-memory-access channel. Software programs a source address, a destination address, a total word budget, a per-run word count, a burst gap setting, a fill word and a control word through a small indexed register port. Once enabled, the channel asks an external arbiter for the bus and then moves 32-bit words. Each word is a combinational read on the memory port and a write in the same cycle. Words go out in atomic bursts whose length is a power of two. A prescaled interval timer spaces the bursts apart.

A run is one batch of the per-run word count. Three modes decide when a run starts and when the channel turns itself off. Immediate mode starts the run as soon as enable is written and shuts down at the end of the run. Repeating mode starts a run on every start pulse and never shuts down by itself. Counted mode starts a run on every start pulse and shuts down once the total budget is used up. The source side can also skip reading entirely and write the fill word instead.

Register indices on `cfg_idx`: 0 source, 1 destination, 2 total, 3 per-run words, 4 gap, 5 fill, 6 control. Control bits: [1:0] destination step mode, [2] destination reload, [4:3] source step mode, [5] source reload, [9:6] block exponent, [10] immediate, [11] repeating, [30] interrupt enable, [31] enable/busy. Step mode codes: 0 increment, 1 decrement, 2 fixed, 3 fill (source only).

Top module: `dma_chan_engine`

## Requirements
- R1: After reset, control bit 31 reads 0 and `bus_req`, `mem_wr` and `irq` are low.
- R2: Writing the source (index 0) or destination (index 1) register clears bits [1:0] of the value. The cleared value reads back and is also loaded as the working address. In increment mode (code 0) the working address rises by 4 after every word.
- R3: In decrement mode (code 1) the working address falls by 4 per word. In fixed mode (code 2) it stays where it is.
- R4: With source mode code 3, no read is issued, and every written word equals the fill register (index 5).
- R5: A side whose reload bit is set (bit 5 source, bit 2 destination) restarts each run from its programmed address. A side whose reload bit is clear carries on from where the previous run stopped.
- R6: A burst is min(2^exponent, words left in the run) writes on consecutive cycles, with `bus_req` held for the whole burst. The exponent is control bits [9:6].
- R7: The gap register holds the interval N in bits [15:0] and the prescale code in bits [17:16]. Code 0, 1, 2 or 3 gives a factor P of 1, 4, 16 or 64. With the grant given at once, the first write of a burst comes N*P+3 cycles after the last write of the burst before it.
- R8: In immediate mode (bit 10), writing control with bit 31 set starts a run of the per-run count. The total register, the repeat bit and `start_evt` have no effect, and bit 31 clears when the run ends.
- R9: In repeating mode (bit 11, bit 10 clear), each `start_evt` pulse moves one run of the per-run count, and bit 31 stays set.
- R10: In counted mode (bits 10 and 11 clear), the channel waits for `start_evt`. Each pulse moves min(per-run count, remaining total) words, and bit 31 clears once the total has been moved.
- R11: `irq` is a one-cycle pulse in the cycle after the channel clears bit 31 by itself. It only occurs when bit 30 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 3 | Register index for write and readback |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Readback of the indexed register |
| start_evt | input | 1 | Single-cycle run trigger |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| mem_rd | output | 1 | Read strobe |
| mem_raddr | output | AW | Read byte address |
| mem_rdata | input | DW | Read data, valid in the same cycle |
| mem_wr | output | 1 | Write strobe |
| mem_waddr | output | AW | Write byte address |
| mem_wdata | output | DW | Write data |
| irq | output | 1 | Completion interrupt pulse |

## Verification
The bench programs an unaligned source address. A design that kept bits [1:0] would read every word from the wrong address. One run is shorter than its block size, so a design that does not shorten the last burst would overrun the word count. Gap spacing is measured with prescale codes 0, 1 and 3, which catches a wrong divider or an off-by-one wait. A counted run uses mixed reload flags and a final run cut short by the total. A design that got this wrong would replay the wrong addresses, move too many words, stay enabled or pulse `irq` when it should not.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_WAIT, ST_REQ, ST_BURST, ST_GAP} dma_state_e;

  localparam logic [1:0] AM_INC  = 2'd0;
  localparam logic [1:0] AM_DEC  = 2'd1;
  localparam logic [1:0] AM_FIX  = 2'd2;
  localparam logic [1:0] AM_FILL = 2'd3;

  localparam logic [2:0] RG_SRC   = 3'd0;
  localparam logic [2:0] RG_DST   = 3'd1;
  localparam logic [2:0] RG_TOTAL = 3'd2;
  localparam logic [2:0] RG_WORDS = 3'd3;
  localparam logic [2:0] RG_GAP   = 3'd4;
  localparam logic [2:0] RG_FILL  = 3'd5;
  localparam logic [2:0] RG_CTRL  = 3'd6;

  localparam int CB_DMODE   = 0;
  localparam int CB_DRELOAD = 2;
  localparam int CB_SMODE   = 3;
  localparam int CB_SRELOAD = 5;
  localparam int CB_BLK     = 6;
  localparam int CB_IMM     = 10;
  localparam int CB_RPT     = 11;
  localparam int CB_IRQEN   = 30;
  localparam int CB_EN      = 31;
  localparam int CTRL_LOW_W = 12;
endpackage

// File: rtl/dma_addr_unit.sv
module dma_addr_unit
  import dma_chan_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_we,
  input  logic [AW-1:0] prog_val,
  input  logic          reload,
  input  logic          step,
  input  logic [1:0]    mode,
  output logic [AW-1:0] prog,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] WORD_BYTES = AW'(4);

  logic [AW-1:0] prog_q, prog_d, work_q, work_d;
  logic [AW-1:0] aligned;

  assign aligned = {prog_val[AW-1:2], 2'b00};

  always_comb begin
    prog_d = prog_q;
    work_d = work_q;
    if (prog_we) begin
      prog_d = aligned;
      work_d = aligned;
    end else if (reload) begin
      work_d = prog_q;
    end else if (step) begin
      case (mode)
        AM_INC:  work_d = work_q + WORD_BYTES;
        AM_DEC:  work_d = work_q - WORD_BYTES;
        default: work_d = work_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q <= '0;
      work_q <= '0;
    end else begin
      prog_q <= prog_d;
      work_q <= work_d;
    end
  end

  assign prog = prog_q;
  assign addr = work_q;

  assert_inc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !prog_we && !reload && mode == AM_INC) |=> (addr == $past(addr) + WORD_BYTES));
  assert_dec_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !prog_we && !reload && mode == AM_DEC) |=> (addr == $past(addr) - WORD_BYTES));
  assert_fixed_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog_we && !reload && mode == AM_FIX) |=> $stable(addr));
endmodule

// File: rtl/dma_gap_timer.sv
module dma_gap_timer #(
  parameter int GAPW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [GAPW-1:0] interval,
  input  logic [1:0]      pre_sel,
  output logic            done
);
  localparam int PREW = 6;

  logic [GAPW-1:0] cnt_q, cnt_d;
  logic [PREW-1:0] pre_q, pre_d, pre_mask;
  logic            tick;

  always_comb begin
    case (pre_sel)
      2'd0:    pre_mask = 6'd0;
      2'd1:    pre_mask = 6'd3;
      2'd2:    pre_mask = 6'd15;
      default: pre_mask = 6'd63;
    endcase
  end

  assign tick = (pre_q == pre_mask);

  always_comb begin
    cnt_d = cnt_q;
    pre_d = pre_q;
    if (load) begin
      cnt_d = interval;
      pre_d = '0;
    end else if (cnt_q != '0) begin
      pre_d = tick ? '0 : pre_q + 1'b1;
      if (tick) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pre_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      pre_q <= pre_d;
    end
  end

  assign done = (cnt_q == '0);

  assert_gap_descend_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int TOTW = 28,
  parameter int RUNW = 24,
  parameter int GAPW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_idx,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic          start_evt,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          mem_rd,
  output logic [AW-1:0] mem_raddr,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_wr,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata,
  output logic          irq
);
  localparam int BLKW = 4;

  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  logic [TOTW-1:0]       total_q, tot_q, tot_d;
  logic [RUNW-1:0]       words_q, run_q, run_d, bst_q, bst_d;
  logic [GAPW-1:0]       gap_ival_q;
  logic [1:0]            gap_pre_q;
  logic [DW-1:0]         fill_q;
  logic [CTRL_LOW_W-1:0] ctrl_q, ctrl_now;
  logic                  irqen_q, en_q, en_d, irq_q, irq_d;
  dma_state_e            st_q, st_d;

  logic wr_ctrl, run_start, move, gap_load, gap_done, run_end, counted;
  logic [RUNW-1:0] blk_words, burst_len, cap_words;
  logic [AW-1:0]   src_prog, dst_prog, src_addr, dst_addr;

  assign wr_ctrl   = cfg_we && (cfg_idx == RG_CTRL);
  assign ctrl_now  = wr_ctrl ? cfg_wdata[CTRL_LOW_W-1:0] : ctrl_q;
  assign counted   = !ctrl_q[CB_IMM] && !ctrl_q[CB_RPT];
  assign blk_words = RUNW'(1) << ctrl_q[CB_BLK +: BLKW];
  assign burst_len = (run_q < blk_words) ? run_q : blk_words;
  assign cap_words = (TOTW'(words_q) > tot_q) ? tot_q[RUNW-1:0] : words_q;

  always_comb begin
    st_d = st_q; en_d = en_q; run_d = run_q; bst_d = bst_q; tot_d = tot_q;
    irq_d = 1'b0; run_start = 1'b0; move = 1'b0; gap_load = 1'b0; run_end = 1'b0;
    if (wr_ctrl) begin
      en_d = cfg_wdata[CB_EN];
      st_d = ST_IDLE;
      if (cfg_wdata[CB_EN]) begin
        tot_d = total_q;
        if (cfg_wdata[CB_IMM]) begin
          run_start = 1'b1;
          run_d     = words_q;
          st_d      = ST_REQ;
        end else begin
          st_d = ST_WAIT;
        end
      end
    end else begin
      case (st_q)
        ST_WAIT: if (start_evt) begin
          run_start = 1'b1;
          run_d     = counted ? cap_words : words_q;
          st_d      = ST_REQ;
        end
        ST_REQ: begin
          if (run_q == '0) run_end = 1'b1;
          else if (bus_gnt) begin
            bst_d = burst_len;
            st_d  = ST_BURST;
          end
        end
        ST_BURST: begin
          move  = 1'b1;
          run_d = run_q - 1'b1;
          bst_d = bst_q - 1'b1;
          if (counted) tot_d = tot_q - 1'b1;
          if (bst_q == RUNW'(1)) begin
            if (run_q == RUNW'(1)) run_end = 1'b1;
            else begin
              gap_load = 1'b1;
              st_d     = ST_GAP;
            end
          end
        end
        ST_GAP: if (gap_done) st_d = ST_REQ;
        default: st_d = st_q;
      endcase
      if (run_end) begin
        if (ctrl_q[CB_IMM] || (counted && tot_d == '0)) begin
          en_d  = 1'b0;
          irq_d = irqen_q;
          st_d  = ST_IDLE;
        end else begin
          st_d = ST_WAIT;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      total_q <= '0; words_q <= '0; gap_ival_q <= '0; gap_pre_q <= '0;
      fill_q <= '0; ctrl_q <= '0; irqen_q <= 1'b0;
      st_q <= ST_IDLE; en_q <= 1'b0; run_q <= '0; bst_q <= '0; tot_q <= '0; irq_q <= 1'b0;
    end else begin
      if (cfg_we && cfg_idx == RG_TOTAL) total_q <= cfg_wdata[TOTW-1:0];
      if (cfg_we && cfg_idx == RG_WORDS) words_q <= cfg_wdata[RUNW-1:0];
      if (cfg_we && cfg_idx == RG_GAP) begin
        gap_ival_q <= cfg_wdata[GAPW-1:0];
        gap_pre_q  <= cfg_wdata[17:16];
      end
      if (cfg_we && cfg_idx == RG_FILL) fill_q <= cfg_wdata[DW-1:0];
      if (wr_ctrl) begin
        ctrl_q  <= cfg_wdata[CTRL_LOW_W-1:0];
        irqen_q <= cfg_wdata[CB_IRQEN];
      end
      st_q <= st_d; en_q <= en_d; run_q <= run_d;
      bst_q <= bst_d; tot_q <= tot_d; irq_q <= irq_d;
    end
  end

  dma_addr_unit #(.AW(AW)) u_src (
    .clk(clk), .rst_n(rst_n_i),
    .prog_we(cfg_we && cfg_idx == RG_SRC), .prog_val(cfg_wdata[AW-1:0]),
    .reload(run_start && ctrl_now[CB_SRELOAD]), .step(move),
    .mode(ctrl_q[CB_SMODE +: 2]), .prog(src_prog), .addr(src_addr));

  dma_addr_unit #(.AW(AW)) u_dst (
    .clk(clk), .rst_n(rst_n_i),
    .prog_we(cfg_we && cfg_idx == RG_DST), .prog_val(cfg_wdata[AW-1:0]),
    .reload(run_start && ctrl_now[CB_DRELOAD]), .step(move),
    .mode(ctrl_q[CB_DMODE +: 2]), .prog(dst_prog), .addr(dst_addr));

  dma_gap_timer #(.GAPW(GAPW)) u_gap (
    .clk(clk), .rst_n(rst_n_i), .load(gap_load),
    .interval(gap_ival_q), .pre_sel(gap_pre_q), .done(gap_done));

  always_comb begin
    case (cfg_idx)
      RG_SRC:   cfg_rdata = 32'(src_prog);
      RG_DST:   cfg_rdata = 32'(dst_prog);
      RG_TOTAL: cfg_rdata = 32'(total_q);
      RG_WORDS: cfg_rdata = 32'(words_q);
      RG_GAP:   cfg_rdata = 32'({gap_pre_q, gap_ival_q});
      RG_FILL:  cfg_rdata = 32'(fill_q);
      RG_CTRL:  cfg_rdata = {en_q, irqen_q, 18'd0, ctrl_q};
      default:  cfg_rdata = '0;
    endcase
  end

  assign bus_req   = (st_q == ST_REQ) || (st_q == ST_BURST);
  assign mem_wr    = (st_q == ST_BURST);
  assign mem_rd    = mem_wr && (ctrl_q[CB_SMODE +: 2] != AM_FILL);
  assign mem_raddr = src_addr;
  assign mem_waddr = dst_addr;
  assign mem_wdata = (ctrl_q[CB_SMODE +: 2] == AM_FILL) ? fill_q : mem_rdata;
  assign irq       = irq_q;

  assert_burst_atomic_R6: assert property (@(posedge clk) disable iff (!rst_n_i)
    (mem_wr && bst_q != RUNW'(1) && !wr_ctrl) |=> (mem_wr && bus_req));
  assert_irq_single_R11: assert property (@(posedge clk) disable iff (!rst_n_i)
    irq |=> !irq);
  assert_irq_after_clear_R11: assert property (@(posedge clk) disable iff (!rst_n_i)
    irq |-> (!en_q && $past(en_q) && $past(irqen_q)));
  assert_total_left_R10: assert property (@(posedge clk) disable iff (!rst_n_i)
    (st_q == ST_WAIT && counted && !$past(wr_ctrl)) |-> (tot_q != '0));
endmodule

// File: tb/sim_dma_chan_engine.sv
module sim_dma_chan_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = 3'd6;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        start_evt = 1'b0;
  logic        bus_req, bus_gnt, mem_rd, mem_wr, irq;
  logic [31:0] mem_raddr, mem_rdata, mem_waddr, mem_wdata;

  int total_cnt = 0;
  int bad_cnt = 0;
  int cyc = 0;
  int nlog = 0;
  int nrd = 0;
  int nirq = 0;
  int lw_cyc [64];
  logic [31:0] lw_a [64];
  logic [31:0] lw_d [64];

  always #5 clk = ~clk;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return 32'hC0DE_0000 ^ (a * 32'd3);
  endfunction

  assign mem_rdata = pat(mem_raddr);
  assign bus_gnt   = bus_req;

  dma_chan_engine u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .start_evt(start_evt),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_rd(mem_rd), .mem_raddr(mem_raddr),
    .mem_rdata(mem_rdata), .mem_wr(mem_wr), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .irq(irq));

  always @(posedge clk) begin
    if (mem_wr && nlog < 64) begin
      lw_cyc[nlog] = cyc;
      lw_a[nlog]   = mem_waddr;
      lw_d[nlog]   = mem_wdata;
      nlog = nlog + 1;
    end
    if (mem_rd) nrd = nrd + 1;
    if (irq) nirq = nirq + 1;
    cyc = cyc + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total_cnt++;
    if (!ok) begin
      bad_cnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0; cfg_idx = 3'd6;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] val);
    @(negedge clk);
    cfg_idx = idx;
    #1 val = cfg_rdata;
    cfg_idx = 3'd6;
  endtask

  task automatic pulse_start;
    @(negedge clk); start_evt = 1'b1;
    @(negedge clk); start_evt = 1'b0;
  endtask

  task automatic wait_off;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!cfg_rdata[31]) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(3'd6, v);
    chk(v[31] == 1'b0, "R1 enable after reset", v, 32'h0);
    chk(!bus_req && !mem_wr && !irq, "R1 outputs idle", {bus_req, mem_wr, irq}, 32'h0);
  endtask

  task automatic t_immediate;
    int b, q; logic [31:0] v;
    b = nlog; q = nirq;
    wr(3'd0, 32'h0000_0102);
    wr(3'd1, 32'h0000_0200);
    wr(3'd2, 32'd1);
    wr(3'd3, 32'd6);
    wr(3'd4, 32'h0001_0002);
    rd(3'd0, v);
    chk(v == 32'h100, "R2 aligned readback", v, 32'h100);
    wr(3'd6, 32'hC000_0C80);
    pulse_start;
    wait_off;
    chk(nlog - b == 6, "R8 word count ignores total", nlog - b, 6);
    for (int k = 0; k < 6; k++) begin
      chk(lw_a[b+k] == 32'h200 + 4*k, "R2 dest increment", lw_a[b+k], 32'h200 + 4*k);
      chk(lw_d[b+k] == pat(32'h100 + 4*k), "R2 source increment", lw_d[b+k], pat(32'h100 + 4*k));
    end
    chk(lw_cyc[b+3] - lw_cyc[b] == 3, "R6 first burst back to back", lw_cyc[b+3] - lw_cyc[b], 3);
    chk(lw_cyc[b+4] - lw_cyc[b+3] == 11, "R7 gap code 1 N=2", lw_cyc[b+4] - lw_cyc[b+3], 11);
    chk(lw_cyc[b+5] - lw_cyc[b+4] == 1, "R6 short last burst", lw_cyc[b+5] - lw_cyc[b+4], 1);
    rd(3'd6, v);
    chk(v[31] == 1'b0, "R8 disabled after run", v, 32'h0);
    chk(nirq - q == 1, "R11 one irq cycle", nirq - q, 1);
  endtask

  task automatic t_dec_fixed;
    int b, q;
    b = nlog; q = nirq;
    wr(3'd0, 32'h40);
    wr(3'd1, 32'h80);
    wr(3'd3, 32'd3);
    wr(3'd4, 32'h0);
    wr(3'd6, 32'h8000_040A);
    wait_off;
    chk(nlog - b == 3, "R3 word count", nlog - b, 3);
    for (int k = 0; k < 3; k++) begin
      chk(lw_a[b+k] == 32'h80, "R3 fixed dest", lw_a[b+k], 32'h80);
      chk(lw_d[b+k] == pat(32'h40 - 4*k), "R3 source decrement", lw_d[b+k], pat(32'h40 - 4*k));
    end
    chk(lw_cyc[b+1] - lw_cyc[b] == 3, "R7 gap code 0 N=0", lw_cyc[b+1] - lw_cyc[b], 3);
    chk(nirq == q, "R11 no irq when disabled", nirq - q, 0);
  endtask

  task automatic t_fill;
    int b, r;
    b = nlog; r = nrd;
    wr(3'd5, 32'hDEAD_BEEF);
    wr(3'd0, 32'h300);
    wr(3'd1, 32'h400);
    wr(3'd3, 32'd4);
    wr(3'd6, 32'h8000_04D8);
    wait_off;
    chk(nlog - b == 4, "R4 fill count", nlog - b, 4);
    chk(nrd == r, "R4 no reads", nrd - r, 0);
    for (int k = 0; k < 4; k++) begin
      chk(lw_d[b+k] == 32'hDEAD_BEEF, "R4 fill data", lw_d[b+k], 32'hDEAD_BEEF);
      chk(lw_a[b+k] == 32'h400 + 4*k, "R6 fill burst addr", lw_a[b+k], 32'h400 + 4*k);
    end
  endtask

  task automatic t_counted;
    int b, q; logic [31:0] v;
    b = nlog; q = nirq;
    wr(3'd0, 32'h500);
    wr(3'd1, 32'h600);
    wr(3'd2, 32'd5);
    wr(3'd3, 32'd2);
    wr(3'd4, 32'h0);
    wr(3'd6, 32'hC000_0060);
    repeat (20) @(negedge clk);
    chk(nlog == b, "R10 waits for start", nlog - b, 0);
    pulse_start; repeat (30) @(negedge clk);
    chk(nlog - b == 2, "R10 first run", nlog - b, 2);
    rd(3'd6, v);
    chk(v[31] == 1'b1, "R10 still enabled", v, 32'h8000_0000);
    pulse_start; repeat (30) @(negedge clk);
    chk(nlog - b == 4, "R10 second run", nlog - b, 4);
    chk(lw_d[b+2] == pat(32'h500), "R5 source reloads", lw_d[b+2], pat(32'h500));
    chk(lw_d[b+3] == pat(32'h504), "R5 source reload step", lw_d[b+3], pat(32'h504));
    chk(lw_a[b+2] == 32'h608, "R5 dest continues", lw_a[b+2], 32'h608);
    chk(nirq == q, "R11 no irq mid budget", nirq - q, 0);
    pulse_start; repeat (30) @(negedge clk);
    chk(nlog - b == 5, "R10 final run capped", nlog - b, 5);
    chk(lw_a[b+4] == 32'h610, "R5 dest continues again", lw_a[b+4], 32'h610);
    rd(3'd6, v);
    chk(v[31] == 1'b0, "R10 disabled at total", v, 32'h0);
    chk(nirq - q == 1, "R11 irq at total", nirq - q, 1);
  endtask

  task automatic t_repeat;
    int b, q; logic [31:0] v;
    b = nlog; q = nirq;
    wr(3'd0, 32'h700);
    wr(3'd1, 32'h800);
    wr(3'd3, 32'd2);
    wr(3'd4, 32'h0003_0001);
    wr(3'd6, 32'h8000_0800);
    pulse_start; repeat (200) @(negedge clk);
    chk(nlog - b == 2, "R9 first run", nlog - b, 2);
    chk(lw_cyc[b+1] - lw_cyc[b] == 67, "R7 gap code 3 N=1", lw_cyc[b+1] - lw_cyc[b], 67);
    pulse_start; repeat (200) @(negedge clk);
    chk(nlog - b == 4, "R9 second run", nlog - b, 4);
    chk(lw_a[b+2] == 32'h808, "R9 dest continues", lw_a[b+2], 32'h808);
    rd(3'd6, v);
    chk(v[31] == 1'b1, "R9 stays enabled", v, 32'h8000_0000);
    chk(nirq == q, "R9 no irq", nirq - q, 0);
    wr(3'd6, 32'h0);
  endtask

  initial begin
    #1_000_000;
    total_cnt++; bad_cnt++;
    $display("FAIL watchdog actual=%0d expected=finished", cyc);
    $display("test done: total=%0d bad=%0d", total_cnt, bad_cnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_immediate;
    t_dec_fixed;
    t_fill;
    t_counted;
    t_repeat;
    $display("test done: total=%0d bad=%0d", total_cnt, bad_cnt);
    $finish;
  end
endmodule